// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences power-down for a small microcontroller core. When the core executes its sleep instruction, the block decides whether sleep really takes effect. If it does, the block stops the oscillator, freezes the I/O pins and clears the watchdog. The watchdog itself keeps counting. Two status bits record what happened. The power-down bit reads 0 once sleep has taken effect. The timeout bit reads 0 after a watchdog event.

Three kinds of event end sleep: an external reset, a watchdog timeout, or an enabled interrupt. An external reset ends sleep by resetting the core. A watchdog or interrupt wake continues the program: the block asks the core to load the address that follows the sleep instruction. After an interrupt wake with the global interrupt enable set, the block asks one cycle later for a branch to the interrupt vector. All pins are plain control and status levels or one-cycle pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: One clock edge after `sleep_exec` is taken, `pd`=0, `to`=1, `osc_en`=0 and `io_hold`=1, and `wdt_clr` is high for exactly that one cycle.
- R2: `pd` is 1 while `por_n` is low and after it is released. Only an effective sleep clears it. No other event sets it again.
- R3: Interrupt source i can wake the block only when `irq_flag[i]` and `irq_en[i]` are both 1. A flag without its enable has no effect. `gie` does not decide whether a wake happens.
- R4: A watchdog or interrupt wake takes effect on the first edge where the cause is present. On that edge `osc_en`=1 and `io_hold`=0, `pc_load` pulses with `pc_target` = `pc_next`, and `core_rst` stays 0.
- R5: After an interrupt wake with `gie`=1, `pc_load` pulses again on the next cycle with `pc_target` = 0x0004. With `gie`=0 no second pulse follows.
- R6: Every exit from sleep pulses `wdt_clr` on the exit edge, whatever the wake source.
- R7: A watchdog wake clears `to`. When a watchdog timeout and an enabled interrupt arrive together, the watchdog is taken as the cause and no vector branch follows.
- R8: `ext_rst_req` passes through two synchroniser flops. During sleep it ends sleep on the third edge, with `core_rst`=1 and a `wdt_clr` pulse. While it is held, `core_rst` stays 1, `sleep_exec` is ignored, and `pd` and `to` keep their values.
- R9: If an enabled interrupt is already pending when `sleep_exec` is taken, sleep is a no-op. The block stays awake, `pd` and `to` keep their values, and `wdt_clr` stays 0.
- R10: Priority while awake is external reset, then watchdog timeout, then sleep. Priority while asleep is external reset, then watchdog, then interrupt.
- R11: A watchdog timeout while awake gives a one-cycle `core_rst` and clears `to`. It does not clear the watchdog or load the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_exec | input | 1 | One-cycle strobe: the core executes the sleep instruction |
| ext_rst_req | input | 1 | Asynchronous external reset request, active high |
| wdt_timeout | input | 1 | One-cycle watchdog timeout pulse |
| irq_flag | input | NSRC | Per-source interrupt flags |
| irq_en | input | NSRC | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| pc_next | input | PCW | Address of the instruction after the sleep instruction |
| pd | output | 1 | Power-down status bit |
| to | output | 1 | Timeout status bit |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |
| osc_en | output | 1 | Oscillator enable |
| io_hold | output | 1 | Freeze I/O pin drive state |
| core_rst | output | 1 | Core reset request |
| pc_load | output | 1 | One-cycle program-counter redirect |
| pc_target | output | PCW | Address to load when `pc_load` is 1 |

## Verification
A wrong sleep state shows at once on `osc_en` and `io_hold`, one edge after the strobe or the wake cause. A corrupted status bit shows on `pd` or `to` on that same edge and stays wrong until the next event that writes it. A wrong wake decision shows in the same cycle as a missing `wdt_clr` pulse or a `pc_load` with the wrong target. A lost vector request shows only one cycle later, as a missing second `pc_load`. Problems in the reset synchroniser show up as a count of edges, so the external reset is checked at exactly the second and third edges.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // Wake or abort cause, listed in priority order
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_EXT  = 2'd1,
    WK_WDT  = 2'd2,
    WK_IRQ  = 2'd3
  } wake_e;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) sh <= '0;
        else        sh <= d;
    end else begin : g_chain
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/swc_wake_eval.sv
module swc_wake_eval
  import swc_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            ext_s,
  input  logic            wdt_timeout,
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] irq_en,
  output wake_e           cause
);
  logic [NSRC-1:0] hit;

  // A source counts only when its own flag and enable are both set
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = irq_flag[g] & irq_en[g];
  end

  always_comb begin
    if (ext_s)            cause = WK_EXT;
    else if (wdt_timeout) cause = WK_WDT;
    else if (|hit)        cause = WK_IRQ;
    else                  cause = WK_NONE;
  end
endmodule

// File: rtl/swc_fsm.sv
module swc_fsm
  import swc_pkg::*;
#(
  parameter int              PCW     = 13,
  parameter logic [PCW-1:0]  ISR_VEC = 13'h0004
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           sleep_exec,
  input  logic           ext_s,
  input  logic           gie,
  input  wake_e          cause,
  input  logic [PCW-1:0] pc_next,
  output logic           asleep,
  output logic           pd,
  output logic           to,
  output logic           wdt_clr,
  output logic           core_rst,
  output logic           pc_load,
  output logic [PCW-1:0] pc_target
);
  logic vec_pend;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      asleep    <= 1'b0;
      pd        <= 1'b1;
      to        <= 1'b1;
      wdt_clr   <= 1'b0;
      core_rst  <= 1'b0;
      pc_load   <= 1'b0;
      pc_target <= '0;
      vec_pend  <= 1'b0;
    end else begin
      wdt_clr  <= 1'b0;
      pc_load  <= 1'b0;
      vec_pend <= 1'b0;
      core_rst <= ext_s;
      if (vec_pend) begin
        pc_load   <= 1'b1;
        pc_target <= ISR_VEC;
      end
      if (asleep) begin
        case (cause)
          WK_EXT: begin
            asleep  <= 1'b0;
            wdt_clr <= 1'b1;
          end
          WK_WDT: begin
            asleep    <= 1'b0;
            wdt_clr   <= 1'b1;
            to        <= 1'b0;
            pc_load   <= 1'b1;
            pc_target <= pc_next;
          end
          WK_IRQ: begin
            asleep    <= 1'b0;
            wdt_clr   <= 1'b1;
            pc_load   <= 1'b1;
            pc_target <= pc_next;
            vec_pend  <= gie;
          end
          default: ;
        endcase
      end else begin
        if (cause == WK_WDT) begin
          core_rst <= 1'b1;
          to       <= 1'b0;
        end else if (sleep_exec && cause == WK_NONE) begin
          asleep  <= 1'b1;
          pd      <= 1'b0;
          to      <= 1'b1;
          wdt_clr <= 1'b1;
        end
      end
    end
  end

  // R1: entering sleep always comes with a watchdog clear
  assert_sleep_clr_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(asleep) |-> (wdt_clr && !pd && to));

  // R2: power-down bit never rises outside power-on reset
  assert_pd_no_rise_R2: assert property (@(posedge clk) disable iff (!por_n)
    !$rose(pd));

  // R6: every exit from sleep clears the watchdog
  assert_wake_clr_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(asleep) |-> wdt_clr);

  // R9: a pending enabled interrupt turns the sleep strobe into a no-op
  assert_noop_R9: assert property (@(posedge clk) disable iff (!por_n)
    (!asleep && sleep_exec && cause == WK_IRQ) |=> (!asleep && !wdt_clr && pd == $past(pd)));

  // R5: a vector request is served on the following cycle
  assert_vec_follow_R5: assert property (@(posedge clk) disable iff (!por_n)
    vec_pend |=> (pc_load && pc_target == ISR_VEC));

  // R8: a synchronised external reset is reflected on core_rst one edge later
  assert_ext_rst_R8: assert property (@(posedge clk) disable iff (!por_n)
    ext_s |=> core_rst);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int             NSRC      = 4,
  parameter int             PCW       = 13,
  parameter logic [PCW-1:0] ISR_VEC   = 13'h0004,
  parameter int             SYNC_STGS = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            sleep_exec,
  input  logic            ext_rst_req,
  input  logic            wdt_timeout,
  input  logic [NSRC-1:0] irq_flag,
  input  logic [NSRC-1:0] irq_en,
  input  logic            gie,
  input  logic [PCW-1:0]  pc_next,
  output logic            pd,
  output logic            to,
  output logic            wdt_clr,
  output logic            osc_en,
  output logic            io_hold,
  output logic            core_rst,
  output logic            pc_load,
  output logic [PCW-1:0]  pc_target
);
  logic  ext_s;
  logic  asleep;
  wake_e cause;

  swc_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (ext_rst_req),
    .q     (ext_s)
  );

  swc_wake_eval #(.NSRC(NSRC)) u_eval (
    .ext_s       (ext_s),
    .wdt_timeout (wdt_timeout),
    .irq_flag    (irq_flag),
    .irq_en      (irq_en),
    .cause       (cause)
  );

  swc_fsm #(.PCW(PCW), .ISR_VEC(ISR_VEC)) u_fsm (
    .clk        (clk),
    .por_n      (por_n),
    .sleep_exec (sleep_exec),
    .ext_s      (ext_s),
    .gie        (gie),
    .cause      (cause),
    .pc_next    (pc_next),
    .asleep     (asleep),
    .pd         (pd),
    .to         (to),
    .wdt_clr    (wdt_clr),
    .core_rst   (core_rst),
    .pc_load    (pc_load),
    .pc_target  (pc_target)
  );

  assign osc_en  = ~asleep;
  assign io_hold = asleep;
endmodule

// File: tb/sim_sleep_wake_ctrl.sv
module sim_sleep_wake_ctrl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sleep_exec = 1'b0;
  logic        ext_rst_req = 1'b0;
  logic        wdt_timeout = 1'b0;
  logic [3:0]  irq_flag = '0;
  logic [3:0]  irq_en = '0;
  logic        gie = 1'b0;
  logic [12:0] pc_next = 13'h0123;
  logic        pd, to, wdt_clr, osc_en, io_hold, core_rst, pc_load;
  logic [12:0] pc_target;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_wake_ctrl u0 (
    .clk(clk), .por_n(por_n), .sleep_exec(sleep_exec), .ext_rst_req(ext_rst_req),
    .wdt_timeout(wdt_timeout), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .pc_next(pc_next), .pd(pd), .to(to), .wdt_clr(wdt_clr), .osc_en(osc_en),
    .io_hold(io_hold), .core_rst(core_rst), .pc_load(pc_load), .pc_target(pc_target)
  );

  typedef struct packed {
    logic       slp;
    logic       wdt;
    logic [3:0] flg;
    logic [3:0] en;
    logic       g;
    logic       e_pd;
    logic       e_to;
    logic       e_slept;
    logic       e_wclr;
    logic       e_rst;
    logic       e_ld;
    logic [12:0] e_tgt;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,4'h0,4'h0,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,13'h0000,4'd2},  // idle after reset, R2
    '{1'b1,1'b0,4'h1,4'h1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,13'h0000,4'd9},  // pending -> no-op, R9
    '{1'b1,1'b0,4'h1,4'h0,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,13'h0000,4'd1},  // sleep taken, R1
    '{1'b0,1'b0,4'h2,4'h0,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,13'h0000,4'd3},  // flag w/o enable ignored, R3
    '{1'b0,1'b0,4'h4,4'h4,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,13'h0123,4'd4},  // irq wake gie=0, R4
    '{1'b0,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,13'h0000,4'd5},  // no vector, R5
    '{1'b1,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,13'h0000,4'd1},  // sleep again, R1
    '{1'b0,1'b0,4'h8,4'h8,1'b1, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,13'h0123,4'd3},  // irq wake gie=1, R3 R10
    '{1'b0,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,13'h0004,4'd5},  // vector branch, R5
    '{1'b0,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,13'h0000,4'd5},  // single branch, R5
    '{1'b1,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,13'h0000,4'd1},  // sleep, R1
    '{1'b0,1'b1,4'h0,4'h0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,13'h0123,4'd7},  // watchdog wake, R7 R6
    '{1'b0,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0000,4'd7},  // TO stays cleared, R7
    '{1'b0,1'b1,4'h0,4'h0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,13'h0000,4'd11}, // awake timeout, R11
    '{1'b0,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0000,4'd11}, // reset pulse ends, R11
    '{1'b1,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,13'h0000,4'd1},  // sleep sets TO, R1
    '{1'b0,1'b1,4'h1,4'h1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,13'h0123,4'd7},  // wdt+irq: wdt wins, R7
    '{1'b0,1'b0,4'h0,4'h0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0000,4'd7}   // no vector after wdt, R7
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, rq, what, act, exp);
  endtask

  task automatic idle_in();
    sleep_exec = 1'b0; wdt_timeout = 1'b0; irq_flag = '0; irq_en = '0; gie = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // Reset state, R2
    repeat (3) @(negedge clk);
    chk_eq("R2", "pd in reset", pd, 1);
    chk_eq("R2", "to in reset", to, 1);
    chk_eq("R1", "osc_en in reset", osc_en, 1);
    chk_eq("R1", "io_hold in reset", io_hold, 0);
    chk_eq("R8", "core_rst in reset", core_rst, 0);
    por_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string t;
      @(negedge clk);
      sleep_exec = VT[i].slp; wdt_timeout = VT[i].wdt;
      irq_flag = VT[i].flg; irq_en = VT[i].en; gie = VT[i].g;
      @(posedge clk); #1;
      t = $sformatf("R%0d", VT[i].rq);
      chk_eq(t, $sformatf("v%0d pd", i), pd, VT[i].e_pd);
      chk_eq(t, $sformatf("v%0d to", i), to, VT[i].e_to);
      chk_eq(t, $sformatf("v%0d io_hold", i), io_hold, VT[i].e_slept);
      chk_eq(t, $sformatf("v%0d osc_en", i), osc_en, !VT[i].e_slept);
      chk_eq(t, $sformatf("v%0d wdt_clr", i), wdt_clr, VT[i].e_wclr);
      chk_eq(t, $sformatf("v%0d core_rst", i), core_rst, VT[i].e_rst);
      chk_eq(t, $sformatf("v%0d pc_load", i), pc_load, VT[i].e_ld);
      if (VT[i].e_ld) chk_eq(t, $sformatf("v%0d pc_target", i), pc_target, VT[i].e_tgt);
    end
    @(negedge clk); idle_in();

    // R8: external reset during sleep
    @(negedge clk); sleep_exec = 1'b1;
    @(negedge clk); sleep_exec = 1'b0; ext_rst_req = 1'b1;
    chk_eq("R8", "asleep before ext reset", io_hold, 1);
    @(posedge clk); @(posedge clk); #1;
    chk_eq("R8", "still asleep at edge 2", io_hold, 1);
    @(posedge clk); #1;
    chk_eq("R8", "wake at edge 3", osc_en, 1);
    chk_eq("R8", "core_rst at edge 3", core_rst, 1);
    chk_eq("R6", "wdt_clr on ext wake", wdt_clr, 1);
    chk_eq("R8", "no pc_load on ext wake", pc_load, 0);
    @(negedge clk); sleep_exec = 1'b1;
    @(posedge clk); #1;
    chk_eq("R8", "sleep ignored in reset", io_hold, 0);
    chk_eq("R8", "no wdt_clr in reset", wdt_clr, 0);
    chk_eq("R8", "core_rst held", core_rst, 1);
    chk_eq("R8", "pd kept", pd, 0);
    chk_eq("R8", "to kept", to, 1);
    @(negedge clk); sleep_exec = 1'b0; ext_rst_req = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk_eq("R8", "core_rst still 1 at edge 2", core_rst, 1);
    @(posedge clk); #1;
    chk_eq("R8", "core_rst released", core_rst, 0);

    // R10: awake, timeout and sleep together -> timeout wins
    @(negedge clk); sleep_exec = 1'b1; wdt_timeout = 1'b1;
    @(posedge clk); #1;
    chk_eq("R10", "timeout beats sleep", io_hold, 0);
    chk_eq("R10", "core_rst on timeout", core_rst, 1);
    @(negedge clk); idle_in();

    // R2: power-on reset mid-run sets PD again
    @(negedge clk); sleep_exec = 1'b1;
    @(negedge clk); sleep_exec = 1'b0;
    chk_eq("R2", "pd cleared by sleep", pd, 0);
    por_n = 1'b0;
    #1;
    chk_eq("R2", "pd after por", pd, 1);
    chk_eq("R2", "to after por", to, 1);
    chk_eq("R2", "awake after por", osc_en, 1);
    @(negedge clk); por_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule